// File: doc/BRIEF.md
# Bidirectional Dual-Clock FIFO Port Controller

This block joins two independently clocked ports, A and B, through a pair of dual-clock FIFOs that carry data in opposite directions. One FIFO runs from A to B and the other from B to A. Each port has one bus. The bus is split into an input word, an output word and an output-enable, so that a pad ring can build the tristate driver. An active-low select and a direction select on each port decide how that bus is used. With the direction select high, the port writes its inbound FIFO. With it low, the port reads the FIFO that arrives from the far side.

Each port sees two flags in its own clock domain. The input-ready flag reports that the FIFO the port writes is not full. The output-ready flag reports that a word is waiting in the output register of the FIFO the port reads. The head word is presented before it is consumed. Whenever output-ready is high, the output bus carries the word that the next read will take. After the last word has been read, the output bus keeps showing that word.

The two clocks may be unrelated or may be the same clock. Pointers cross between the domains in Gray code through two-stage synchronizers.

Top module: `bidir_fifo_ctl`

## Requirements
- R1: A port's output-enable is high exactly when its select is low (0) and its direction select is low (0). It follows these inputs combinationally, with no clock delay. In every other case the bus is released (output-enable 0).
- R2: On a rising edge of clk_a, port A stores din_a into the A-to-B FIFO when all four of these hold: cs_a_n=0, wr_sel_a=1, wen_a=1 and irdy_a=1.
- R3: On a rising edge of clk_a, port A removes one word from the B-to-A FIFO when all four of these hold: cs_a_n=0, wr_sel_a=0, ren_a=1 and ordy_a=1. While ordy_a=1, dout_a carries the word that such a read removes.
- R4: Port B mirrors port A, using clk_b. It writes into the B-to-A FIFO and reads from the A-to-B FIFO under the same conditions, and its flags irdy_b and ordy_b refer to those FIFOs.
- R5: Each direction delivers its words in the order they were accepted, with none lost or duplicated. This holds while both directions run at once on unrelated clocks.
- R6: A write attempted while the port's input-ready is 0 is discarded. The FIFO contents do not change.
- R7: When output-ready is 0, a read has no effect. The output bus keeps the last word delivered, or 0 if no word has been delivered since reset.
- R8: While a port's write enable and read enable are both 0, toggling its select or direction select moves no data.
- R9: After reset, both output-ready flags are 0 and both input-ready flags are 1.
- R10: With the reading side idle, a direction accepts exactly DEPTH+1 words. DEPTH words are held in the array and one in the output register. It never holds more than DEPTH+1 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| clk_a | input | 1 | Port A clock |
| cs_a_n | input | 1 | Port A select, active low |
| wr_sel_a | input | 1 | Port A direction: 1 write, 0 read |
| wen_a | input | 1 | Port A write enable |
| ren_a | input | 1 | Port A read enable |
| din_a | input | WIDTH | Port A inbound word |
| dout_a | output | WIDTH | Port A outbound word (head of B-to-A FIFO) |
| doe_a | output | 1 | Port A bus drive enable |
| irdy_a | output | 1 | A-to-B FIFO not full, clk_a domain |
| ordy_a | output | 1 | B-to-A word available, clk_a domain |
| clk_b | input | 1 | Port B clock |
| cs_b_n | input | 1 | Port B select, active low |
| wr_sel_b | input | 1 | Port B direction: 1 write, 0 read |
| wen_b | input | 1 | Port B write enable |
| ren_b | input | 1 | Port B read enable |
| din_b | input | WIDTH | Port B inbound word |
| dout_b | output | WIDTH | Port B outbound word (head of A-to-B FIFO) |
| doe_b | output | 1 | Port B bus drive enable |
| irdy_b | output | 1 | B-to-A FIFO not full, clk_b domain |
| ordy_b | output | 1 | A-to-B word available, clk_b domain |

## Verification
The hardest state to reach is a direction that is completely full while its reading port stays deselected. Write attempts must keep arriving after input-ready has fallen, and the selects must then toggle with both enables low before any drain starts. The stimulus parks the far port with its select high and streams writes for three times the depth. This lets the output register fill from the array without a read, and the settled count must reach exactly DEPTH+1. A select-toggling phase follows, and only then does the far port drain. During the concurrent phase both ports make random choices on clocks of 5 ns and 7.3 ns, so flag crossings land at varying phases.

// File: rtl/bdf_pkg.sv
package bdf_pkg;
    localparam int DATA_W_DEF = 18;
    localparam int DEPTH_DEF  = 512;

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction
endpackage

// File: rtl/bdf_sync.sv
module bdf_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/bdf_dcfifo.sv
module bdf_dcfifo
    import bdf_pkg::*;
#(
    parameter int WIDTH = DATA_W_DEF,
    parameter int DEPTH = DEPTH_DEF
) (
    input  logic             rst_n,
    input  logic             wclk,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    output logic             in_ready,
    input  logic             rclk,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             out_ready
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } wside_t;

    typedef struct packed {
        logic [PW-1:0]    bin;
        logic [PW-1:0]    gray;
        logic             valid;
        logic [WIDTH-1:0] data;
    } rside_t;

    wside_t w_d, w_q;
    rside_t r_d, r_q;
    logic [WIDTH-1:0] mem [DEPTH];

    logic [PW-1:0] rgray_s, wgray_s, rbin_s, wbin_s;
    logic          full, mem_empty, take, accept;

    bdf_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(rst_n), .din(r_q.gray), .dout(rgray_s));
    bdf_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rst_n), .din(w_q.gray), .dout(wgray_s));

    // write domain next state
    always_comb begin
        rbin_s = PW'(gray2bin(32'(rgray_s)));
        full   = (w_q.bin - rbin_s) == PW'(DEPTH);
        accept = push && !full;
        w_d    = w_q;
        if (accept) begin
            w_d.bin  = w_q.bin + 1'b1;
            w_d.gray = PW'(bin2gray(32'(w_d.bin)));
        end
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    always_ff @(posedge wclk) begin
        if (accept) mem[w_q.bin[AW-1:0]] <= wdata;
    end

    // read domain next state: output register refills from the array
    always_comb begin
        wbin_s    = PW'(gray2bin(32'(wgray_s)));
        mem_empty = (r_q.bin == wbin_s);
        take      = pop && r_q.valid;
        r_d       = r_q;
        if (take) r_d.valid = 1'b0;
        if ((!r_q.valid || take) && !mem_empty) begin
            r_d.data  = mem[r_q.bin[AW-1:0]];
            r_d.bin   = r_q.bin + 1'b1;
            r_d.gray  = PW'(bin2gray(32'(r_d.bin)));
            r_d.valid = 1'b1;
        end
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign in_ready  = !full;
    assign out_ready = r_q.valid;
    assign rdata     = r_q.data;

    // R10
    no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        (w_q.bin - rbin_s) <= PW'(DEPTH));

    // R6
    drop_when_full_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        (push && !in_ready) |=> (w_q.bin == $past(w_q.bin)));

    // R7
    hold_when_empty_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (!out_ready && mem_empty) |=> $stable(rdata));

    // R7
    drain_drop_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (out_ready && pop && mem_empty) |=> !out_ready);

    // R5
    no_skip_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        1'b1 |=> ((r_q.bin - $past(r_q.bin)) <= PW'(1)));
endmodule

// File: rtl/bdf_port.sv
module bdf_port (
    input  logic cs_n,
    input  logic wr_sel,
    input  logic wen,
    input  logic ren,
    input  logic in_ready,
    input  logic out_ready,
    output logic push,
    output logic pop,
    output logic oe
);
    logic sel, rd_dir;

    always_comb begin
        sel    = !cs_n;
        rd_dir = sel && !wr_sel;
        oe     = rd_dir;
        push   = sel && wr_sel && wen && in_ready;
        pop    = rd_dir && ren && out_ready;
    end
endmodule

// File: rtl/bidir_fifo_ctl.sv
module bidir_fifo_ctl
    import bdf_pkg::*;
#(
    parameter int WIDTH = DATA_W_DEF,
    parameter int DEPTH = DEPTH_DEF
) (
    input  logic             rst_n,
    input  logic             clk_a,
    input  logic             cs_a_n,
    input  logic             wr_sel_a,
    input  logic             wen_a,
    input  logic             ren_a,
    input  logic [WIDTH-1:0] din_a,
    output logic [WIDTH-1:0] dout_a,
    output logic             doe_a,
    output logic             irdy_a,
    output logic             ordy_a,
    input  logic             clk_b,
    input  logic             cs_b_n,
    input  logic             wr_sel_b,
    input  logic             wen_b,
    input  logic             ren_b,
    input  logic [WIDTH-1:0] din_b,
    output logic [WIDTH-1:0] dout_b,
    output logic             doe_b,
    output logic             irdy_b,
    output logic             ordy_b
);
    logic push_a, pop_a, push_b, pop_b;

    bdf_port u_port_a (
        .cs_n(cs_a_n), .wr_sel(wr_sel_a), .wen(wen_a), .ren(ren_a),
        .in_ready(irdy_a), .out_ready(ordy_a),
        .push(push_a), .pop(pop_a), .oe(doe_a)
    );

    bdf_port u_port_b (
        .cs_n(cs_b_n), .wr_sel(wr_sel_b), .wen(wen_b), .ren(ren_b),
        .in_ready(irdy_b), .out_ready(ordy_b),
        .push(push_b), .pop(pop_b), .oe(doe_b)
    );

    bdf_dcfifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fifo_ab (
        .rst_n(rst_n),
        .wclk(clk_a), .push(push_a), .wdata(din_a), .in_ready(irdy_a),
        .rclk(clk_b), .pop(pop_b), .rdata(dout_b), .out_ready(ordy_b)
    );

    bdf_dcfifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fifo_ba (
        .rst_n(rst_n),
        .wclk(clk_b), .push(push_b), .wdata(din_b), .in_ready(irdy_b),
        .rclk(clk_a), .pop(pop_a), .rdata(dout_a), .out_ready(ordy_a)
    );

    // R1
    bus_dir_a_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
        !(push_a && doe_a));

    // R1
    bus_dir_b_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
        !(push_b && doe_b));

    // R8
    idle_a_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
        (!wen_a && !ren_a) |-> !(push_a || pop_a));

    // R8
    idle_b_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
        (!wen_b && !ren_b) |-> !(push_b || pop_b));
endmodule

// File: tb/test_bidir_fifo_ctl.sv
`timescale 1ns/1ps
module test_bidir_fifo_ctl;
    localparam int W = 18;
    localparam int D = 16;

    logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
    logic cs_a_n = 1'b1, wr_sel_a = 1'b0, wen_a = 1'b0, ren_a = 1'b0;
    logic cs_b_n = 1'b1, wr_sel_b = 1'b0, wen_b = 1'b0, ren_b = 1'b0;
    logic [W-1:0] din_a = '0, din_b = '0;
    logic [W-1:0] dout_a, dout_b;
    logic doe_a, doe_b, irdy_a, irdy_b, ordy_a, ordy_b;

    int checks = 0, errors = 0;
    int mode_a = 0, mode_b = 0;
    int dropped_a = 0, dropped_b = 0;
    int sz_ab, sz_ba;
    logic [W-1:0] q_ab[$];
    logic [W-1:0] q_ba[$];
    logic [W-1:0] last_ab = '0, last_ba = '0;
    logic [W-1:0] seq_a = 18'h00000, seq_b = 18'h20000;

    always #2.5  clk_a = ~clk_a;
    always #3.65 clk_b = ~clk_b;

    bidir_fifo_ctl #(.WIDTH(W), .DEPTH(D)) i_bidir_fifo_ctl (
        .rst_n(rst_n),
        .clk_a(clk_a), .cs_a_n(cs_a_n), .wr_sel_a(wr_sel_a), .wen_a(wen_a), .ren_a(ren_a),
        .din_a(din_a), .dout_a(dout_a), .doe_a(doe_a), .irdy_a(irdy_a), .ordy_a(ordy_a),
        .clk_b(clk_b), .cs_b_n(cs_b_n), .wr_sel_b(wr_sel_b), .wen_b(wen_b), .ren_b(ren_b),
        .din_b(din_b), .dout_b(dout_b), .doe_b(doe_b), .irdy_b(irdy_b), .ordy_b(ordy_b)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic pick(input int mode, output logic cs, output logic wr, output logic we, output logic re);
        case (mode)
            1: begin cs = ($urandom % 4) == 0; wr = 1'($urandom); we = 1'($urandom); re = 1'($urandom); end
            2: begin cs = 1'b0; wr = 1'b1; we = 1'b1; re = 1'b0; end
            3: begin cs = 1'b0; wr = 1'b0; we = 1'b0; re = 1'b1; end
            4: begin cs = 1'($urandom); wr = 1'($urandom); we = 1'b0; re = 1'b0; end
            default: begin cs = 1'b1; wr = 1'($urandom); we = 1'($urandom); re = 1'($urandom); end
        endcase
    endtask

    // port A driver and model (R2, R3)
    always @(negedge clk_a) begin
        pick(mode_a, cs_a_n, wr_sel_a, wen_a, ren_a);
        din_a = seq_a;
        #1;
        chk(doe_a == (!cs_a_n && !wr_sel_a), "R1 port A oe", 32'(doe_a), 32'(!cs_a_n && !wr_sel_a));
        if (rst_n) begin
            if (ordy_a) begin
                chk(q_ba.size() > 0, "R5 A ready without data", 32'(q_ba.size()), 32'd1);
                if (q_ba.size() > 0)
                    chk(dout_a == q_ba[0], "R3 A head word", 32'(dout_a), 32'(q_ba[0]));
            end else begin
                chk(dout_a == last_ba, "R7 A holds last", 32'(dout_a), 32'(last_ba));
            end
            if (!cs_a_n && wr_sel_a && wen_a) begin
                if (irdy_a) begin q_ab.push_back(din_a); seq_a = seq_a + 1'b1; end
                else dropped_a++;
            end
            if (!cs_a_n && !wr_sel_a && ren_a && ordy_a && q_ba.size() > 0) begin
                last_ba = q_ba.pop_front();
            end
            chk(q_ab.size() <= D + 1, "R10 A->B bound", 32'(q_ab.size()), 32'(D + 1));
        end
    end

    // port B driver and model (R4)
    always @(negedge clk_b) begin
        pick(mode_b, cs_b_n, wr_sel_b, wen_b, ren_b);
        din_b = seq_b;
        #1;
        chk(doe_b == (!cs_b_n && !wr_sel_b), "R1 port B oe", 32'(doe_b), 32'(!cs_b_n && !wr_sel_b));
        if (rst_n) begin
            if (ordy_b) begin
                chk(q_ab.size() > 0, "R5 B ready without data", 32'(q_ab.size()), 32'd1);
                if (q_ab.size() > 0)
                    chk(dout_b == q_ab[0], "R4 B head word", 32'(dout_b), 32'(q_ab[0]));
            end else begin
                chk(dout_b == last_ab, "R7 B holds last", 32'(dout_b), 32'(last_ab));
            end
            if (!cs_b_n && wr_sel_b && wen_b) begin
                if (irdy_b) begin q_ba.push_back(din_b); seq_b = seq_b + 1'b1; end
                else dropped_b++;
            end
            if (!cs_b_n && !wr_sel_b && ren_b && ordy_b && q_ab.size() > 0) begin
                last_ab = q_ab.pop_front();
            end
            chk(q_ba.size() <= D + 1, "R10 B->A bound", 32'(q_ba.size()), 32'(D + 1));
        end
    end

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (6) @(posedge clk_a);
        rst_n = 1'b1;
        repeat (4) @(posedge clk_a);
        @(negedge clk_a); #2;
        // R9
        chk(irdy_a && irdy_b, "R9 input ready after reset", {irdy_a, irdy_b}, 2'b11);
        chk(!ordy_a && !ordy_b, "R9 output ready after reset", {ordy_a, ordy_b}, 2'b00);

        // R5: concurrent random traffic in both directions
        @(posedge clk_a); mode_a = 1; mode_b = 1;
        repeat (4000) @(posedge clk_a);
        mode_a = 3; mode_b = 3;
        repeat (300) @(posedge clk_a);
        chk(q_ab.size() == 0 && q_ba.size() == 0, "R5 both drained", 32'(q_ab.size() + q_ba.size()), 32'd0);
        chk(!ordy_a && !ordy_b, "R7 empty flags", {ordy_a, ordy_b}, 2'b00);

        // R6, R10: fill A->B with port B deselected
        mode_a = 2; mode_b = 0;
        repeat (3 * D + 40) @(posedge clk_a);
        mode_a = 0;
        repeat (20) @(posedge clk_a);
        chk(q_ab.size() == D + 1, "R10 A->B capacity", 32'(q_ab.size()), 32'(D + 1));
        chk(dropped_a > 0, "R6 writes dropped when full", 32'(dropped_a), 32'd1);
        @(negedge clk_a); #2;
        chk(!irdy_a, "R6 input ready low when full", 32'(irdy_a), 32'd0);

        // R8: toggle selects with enables low
        sz_ab = q_ab.size(); sz_ba = q_ba.size();
        mode_a = 4; mode_b = 4;
        repeat (200) @(posedge clk_a);
        mode_a = 0; mode_b = 0;
        repeat (20) @(posedge clk_a);
        chk(q_ab.size() == sz_ab && q_ba.size() == sz_ba, "R8 no transfer on toggle",
            32'(q_ab.size()), 32'(sz_ab));
        @(negedge clk_a); #2;
        chk(!irdy_a, "R8 still full", 32'(irdy_a), 32'd0);

        // drain A->B
        mode_b = 3;
        repeat (200) @(posedge clk_a);
        mode_b = 0;
        repeat (20) @(posedge clk_a);
        chk(q_ab.size() == 0, "R5 A->B drained in order", 32'(q_ab.size()), 32'd0);

        // R4, R10: mirror fill B->A
        mode_b = 2;
        repeat (5 * D + 60) @(posedge clk_a);
        mode_b = 0;
        repeat (30) @(posedge clk_a);
        chk(q_ba.size() == D + 1, "R10 B->A capacity", 32'(q_ba.size()), 32'(D + 1));
        chk(dropped_b > 0, "R6 B writes dropped", 32'(dropped_b), 32'd1);
        mode_a = 3;
        repeat (200) @(posedge clk_a);
        mode_a = 0;
        repeat (20) @(posedge clk_a);
        chk(q_ba.size() == 0, "R4 B->A drained", 32'(q_ba.size()), 32'd0);
        @(negedge clk_a); #2;
        chk(irdy_a && irdy_b, "R2 ready again after drain", {irdy_a, irdy_b}, 2'b11);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule